// File: doc/BRIEF.md
# Memory Request FIFO Encoder

This block gives a hardware datapath a simple way to move words to and from a shared memory subsystem. The only link to that subsystem is one outgoing word FIFO and one incoming word FIFO. The caller loads a small local buffer, then pulses a start strobe with a direction, a byte length and a byte address. The block turns the command into a two-word request header and pushes it into the outgoing FIFO. For a write, the buffered words follow the header in the same stream. For a read, the block waits on the incoming FIFO and stores each returned word into the buffer in arrival order.

A `done` level tells the caller's state machine when the whole transfer has moved, so the caller can simply stall on it. Single-word and burst transfers share one path. A command whose length or address cannot be encoded is refused: the block raises an error flag and writes nothing into either FIFO. The local buffer is a register array inside the block. The caller writes it through a write port and reads it through an index-addressed read port.

Top module: `memReqEncoder`

## Requirements
- R1: While reset is held and just after it, `done` is 1, `err` is 0, `outValid` is 0 and `inReady` is 0.
- R2: The first outgoing word of an accepted command is the header word: bit 31 is the direction (1 = write, 0 = read), bits 30:24 are zero and bits 23:0 are the byte length. The second outgoing word is the 32-bit byte address.
- R3: For a write of N words, the N words after the header are buffer entries 0, 1, ... N-1, in that order, each pushed exactly once.
- R4: For a read of N words, after the header `inReady` is high until N words have been popped. Popped word k is stored in buffer entry k and can be read on `bufRdData` once `done` is high.
- R5: `done` is 0 in the cycle after a legal command is accepted. It becomes 1 in the cycle after the handshake that moves the last data word, and stays 1 until the next accepted command.
- R6: A command is refused if its length is zero, not a multiple of 4, or more than `MAX_WORDS`*4, or if address bits 1:0 are not zero. A refused command sets `err`, leaves `done` at 1 and pushes and pops no word. The next legal command clears `err`.
- R7: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` holds its value. Gaps in `inValid` of any length lose no word and duplicate none.
- R8: A `cmdStart` pulse while `done` is 0 is ignored.
- R9: A caller buffer write while `done` is 0 is ignored and leaves the addressed entry unchanged.
- R10: Transfers of 1 word and of `MAX_WORDS` (64) words both complete correctly in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Command strobe, sampled while `done` is 1 |
| cmdWrite | input | 1 | Direction: 1 = write to memory, 0 = read |
| cmdLenBytes | input | 24 | Transfer length in bytes |
| cmdAddr | input | 32 | Byte address of the first word |
| done | output | 1 | High when idle and the last transfer has finished |
| err | output | 1 | The last command was refused |
| bufWrEn | input | 1 | Caller write strobe for the local buffer |
| bufWrIdx | input | 6 | Caller write index |
| bufWrData | input | 32 | Caller write data |
| bufRdIdx | input | 6 | Caller read index |
| bufRdData | output | 32 | Buffer entry at `bufRdIdx` |
| outData | output | 32 | Outgoing FIFO word |
| outValid | output | 1 | Outgoing word valid |
| outReady | input | 1 | Outgoing FIFO can take a word |
| inData | input | 32 | Incoming FIFO word |
| inValid | input | 1 | Incoming word valid |
| inReady | output | 1 | Block takes the incoming word |

## Verification
The bench throttles `outReady` and `inValid` in two patterns: every other cycle, and pseudo-random. A design that advances its word index without a handshake would then skip or repeat words, and the scoreboard would catch the mismatch. It times the rise of `done` against the final handshake, so a design that raises it one cycle early or late is caught. It sends all four kinds of illegal command. A design that still emitted a header for one of them would produce an unexpected push. It fires a second start and a buffer write in the middle of a busy transfer; an implementation that honoured either would emit extra words or corrupt the entry. Finally it runs full 64-word bursts, where a counter one bit too narrow would finish early.

// File: rtl/memReqPkg.sv
package memReqPkg;

  typedef enum logic [1:0] {
    SEL_HDR0,
    SEL_HDR1,
    SEL_DATA
  } outSelT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR0,
    ST_HDR1,
    ST_WDATA,
    ST_RDATA
  } ctrlStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic   loadCmd;    // latch command fields, clear word index
    logic   stepIdx;    // advance word index
    logic   captureIn;  // store incoming word at current index
    logic   hostOpen;   // caller buffer writes permitted
    outSelT outSel;     // outgoing word source
  } dpStrobeT;

endpackage

// File: rtl/memReqDatapath.sv
module memReqDatapath
  import memReqPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 24,
  parameter int MAX_WORDS = 64,
  parameter int IDX_W     = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic              cmdWrite,
  input  logic [LEN_W-1:0]  cmdLenBytes,
  input  logic [DATA_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic              bufWrEn,
  input  logic [IDX_W-1:0]  bufWrIdx,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic [IDX_W-1:0]  bufRdIdx,
  output logic [DATA_W-1:0] bufRdData,
  output logic [DATA_W-1:0] outData,
  output logic              cmdLegal,
  output logic              opWrite,
  output logic              lastWord
);

  localparam int MAX_BYTES = MAX_WORDS * 4;

  logic [LEN_W-1:0]  lenReg;
  logic [DATA_W-1:0] addrReg;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  lastIdx;
  logic [LEN_W-1:0]  wordsMinusOne;
  logic [DATA_W-1:0] wordStore [MAX_WORDS];
  logic [DATA_W-1:0] hdrWord;

  // command legality
  always_comb begin
    cmdLegal = (cmdLenBytes != '0) && (cmdLenBytes[1:0] == 2'b00)
             && (cmdLenBytes <= LEN_W'(MAX_BYTES)) && (cmdAddr[1:0] == 2'b00);
    wordsMinusOne = (cmdLenBytes >> 2) - LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg  <= '0;
      addrReg <= '0;
      opWrite <= 1'b0;
      lastIdx <= '0;
      idx     <= '0;
    end else if (strobe.loadCmd) begin
      lenReg  <= cmdLenBytes;
      addrReg <= cmdAddr;
      opWrite <= cmdWrite;
      lastIdx <= wordsMinusOne[IDX_W-1:0];
      idx     <= '0;
    end else if (strobe.stepIdx) begin
      idx <= idx + IDX_W'(1);
    end
  end

  assign lastWord = (idx == lastIdx);

  // local buffer: incoming capture has priority, caller only while idle
  always_ff @(posedge clk) begin
    if (strobe.captureIn) begin
      wordStore[idx] <= inData;
    end else if (strobe.hostOpen && bufWrEn) begin
      wordStore[bufWrIdx] <= bufWrData;
    end
  end

  assign bufRdData = wordStore[bufRdIdx];

  always_comb begin
    hdrWord              = '0;
    hdrWord[DATA_W-1]    = opWrite;
    hdrWord[LEN_W-1:0]   = lenReg;
    case (strobe.outSel)
      SEL_HDR0: outData = hdrWord;
      SEL_HDR1: outData = addrReg;
      default:  outData = wordStore[idx];
    endcase
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepIdx |-> (idx <= lastIdx)); // R10
  AST_CAPTURE_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureIn |-> !opWrite); // R4

endmodule

// File: rtl/memReqCtrl.sv
module memReqCtrl
  import memReqPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdStart,
  input  logic     cmdLegal,
  input  logic     opWrite,
  input  logic     lastWord,
  input  logic     outReady,
  input  logic     inValid,
  output dpStrobeT strobe,
  output logic     outValid,
  output logic     inReady,
  output logic     done,
  output logic     err
);

  ctrlStateT state, nextState;

  always_comb begin
    strobe        = '0;
    strobe.outSel = SEL_HDR0;
    outValid      = 1'b0;
    inReady       = 1'b0;
    nextState     = state;
    case (state)
      ST_IDLE: begin
        strobe.hostOpen = 1'b1;
        if (cmdStart && cmdLegal) begin
          strobe.loadCmd = 1'b1;
          nextState      = ST_HDR0;
        end
      end
      ST_HDR0: begin
        outValid = 1'b1;
        if (outReady) nextState = ST_HDR1;
      end
      ST_HDR1: begin
        outValid      = 1'b1;
        strobe.outSel = SEL_HDR1;
        if (outReady) nextState = opWrite ? ST_WDATA : ST_RDATA;
      end
      ST_WDATA: begin
        outValid      = 1'b1;
        strobe.outSel = SEL_DATA;
        if (outReady) begin
          strobe.stepIdx = 1'b1;
          if (lastWord) nextState = ST_IDLE;
        end
      end
      ST_RDATA: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.captureIn = 1'b1;
          strobe.stepIdx   = 1'b1;
          if (lastWord) nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      err   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && cmdStart) err <= !cmdLegal;
    end
  end

  assign done = (state == ST_IDLE);

  AST_REFUSE_STAYS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (done && cmdStart && !cmdLegal) |=> (done && err)); // R6
  AST_ACCEPT_DROPS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (done && cmdStart && cmdLegal) |=> (!done && !err)); // R5
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid); // R7
  AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outValid, inReady, done})); // R8

endmodule

// File: rtl/memReqEncoder.sv
module memReqEncoder
  import memReqPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 24,
  parameter int MAX_WORDS = 64,
  localparam int IDX_W    = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdWrite,
  input  logic [LEN_W-1:0]  cmdLenBytes,
  input  logic [DATA_W-1:0] cmdAddr,
  output logic              done,
  output logic              err,
  input  logic              bufWrEn,
  input  logic [IDX_W-1:0]  bufWrIdx,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic [IDX_W-1:0]  bufRdIdx,
  output logic [DATA_W-1:0] bufRdData,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady
);

  dpStrobeT strobe;
  logic     cmdLegal;
  logic     opWrite;
  logic     lastWord;

  memReqCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdStart (cmdStart),
    .cmdLegal (cmdLegal),
    .opWrite  (opWrite),
    .lastWord (lastWord),
    .outReady (outReady),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid),
    .inReady  (inReady),
    .done     (done),
    .err      (err)
  );

  memReqDatapath #(
    .DATA_W    (DATA_W),
    .LEN_W     (LEN_W),
    .MAX_WORDS (MAX_WORDS),
    .IDX_W     (IDX_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdWrite    (cmdWrite),
    .cmdLenBytes (cmdLenBytes),
    .cmdAddr     (cmdAddr),
    .inData      (inData),
    .bufWrEn     (bufWrEn),
    .bufWrIdx    (bufWrIdx),
    .bufWrData   (bufWrData),
    .bufRdIdx    (bufRdIdx),
    .bufRdData   (bufRdData),
    .outData     (outData),
    .cmdLegal    (cmdLegal),
    .opWrite     (opWrite),
    .lastWord    (lastWord)
  );

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData)); // R7

endmodule

// File: tb/memReqEncoder_tb_top.sv
`timescale 1ns/1ps
module memReqEncoder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0;
  logic        cmdWrite = 1'b0;
  logic [23:0] cmdLenBytes = '0;
  logic [31:0] cmdAddr = '0;
  logic        done, err;
  logic        bufWrEn = 1'b0;
  logic [5:0]  bufWrIdx = '0;
  logic [31:0] bufWrData = '0;
  logic [5:0]  bufRdIdx = '0;
  logic [31:0] bufRdData;
  logic [31:0] outData;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;

  always #2 clk = ~clk;

  memReqEncoder dut_i (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdWrite(cmdWrite),
    .cmdLenBytes(cmdLenBytes), .cmdAddr(cmdAddr), .done(done), .err(err),
    .bufWrEn(bufWrEn), .bufWrIdx(bufWrIdx), .bufWrData(bufWrData),
    .bufRdIdx(bufRdIdx), .bufRdData(bufRdData), .outData(outData),
    .outValid(outValid), .outReady(outReady), .inData(inData),
    .inValid(inValid), .inReady(inReady)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int lastHsCycle = 0;
  int doneCycle = 0;
  int pushCount = 0;
  int memIdx = 0;
  int rdCount = 0;
  int stallMode = 0;
  logic prevDone = 1'b1;
  logic [7:0] lfsr = 8'hA5;
  logic [31:0] expQ [$];
  logic [31:0] mdl [64];
  logic [31:0] rdWords [64];
  logic [31:0] expW;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit gate();
    if (stallMode == 0) return 1'b1;
    if (stallMode == 1) return cyc[0];
    return lfsr[0] | lfsr[3];
  endfunction

  // FIFO side model: drive just after the clock edge
  always @(posedge clk) begin
    #1;
    lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady = gate();
    inData   = (memIdx < 64) ? rdWords[memIdx] : 32'h0;
    inValid  = (memIdx < rdCount) && gate();
  end

  // monitor / scoreboard at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (outValid && outReady) begin
      pushCount++;
      lastHsCycle = cyc;
      if (expQ.size() == 0) begin
        chk(1'b0, "R2/R3/R6/R8", "unexpected outgoing word", outData, 32'h0);
      end else begin
        expW = expQ.pop_front();
        chk(outData == expW, "R2/R3/R7", "outgoing word", outData, expW);
      end
    end
    if (inValid && inReady) begin
      lastHsCycle = cyc;
      memIdx++;
    end
    if (done && !prevDone) doneCycle = cyc;
    prevDone = done;
  end

  task automatic loadBuffer(input logic [31:0] seed);
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); #1;
      bufWrEn = 1'b1; bufWrIdx = 6'(i); bufWrData = seed ^ (32'h0101_0101 * i);
      mdl[i] = seed ^ (32'h0101_0101 * i);
    end
    @(posedge clk); #1;
    bufWrEn = 1'b0;
  endtask

  task automatic runCmd(input bit wr, input logic [23:0] len,
                        input logic [31:0] addr, input bit poke);
    bit legal;
    int n;
    int pushBefore;
    int guard;
    legal = (len != 0) && (len[1:0] == 2'b00) && (len <= 24'd256) && (addr[1:0] == 2'b00);
    n = int'(len) / 4;
    pushBefore = pushCount;
    if (legal) begin
      expQ.push_back({wr, 7'b0, len});
      expQ.push_back(addr);
      if (wr) for (int i = 0; i < n; i++) expQ.push_back(mdl[i]);
    end
    rdCount = 0;
    memIdx  = 0;
    if (legal && !wr) begin
      for (int i = 0; i < n; i++) rdWords[i] = 32'hC0DE_0000 ^ addr ^ (32'h0011_0003 * i);
      rdCount = n;
    end
    @(posedge clk); #1;
    cmdStart = 1'b1; cmdWrite = wr; cmdLenBytes = len; cmdAddr = addr;
    @(posedge clk); #1;
    cmdStart = 1'b0;
    @(negedge clk); #1;
    if (!legal) begin
      chk(done && err, "R6", "refused command: done and err", {30'b0, done, err}, 32'h3);
      repeat (4) @(negedge clk);
      #1;
      chk(pushCount == pushBefore, "R6", "refused command pushes nothing", pushCount, pushBefore);
      chk(memIdx == 0, "R6", "refused command pops nothing", memIdx, 0);
      return;
    end
    chk(!done, "R5", "done low after accept", done, 0);
    chk(!err, "R6", "err cleared by legal command", err, 0);
    if (poke) begin
      @(posedge clk); #1;
      cmdStart = 1'b1; cmdWrite = ~wr; cmdLenBytes = 24'd8; cmdAddr = 32'h0000_0040;
      bufWrEn = 1'b1; bufWrIdx = 6'd63; bufWrData = 32'hDEAD_BEEF;
      @(posedge clk); #1;
      cmdStart = 1'b0; bufWrEn = 1'b0;
    end
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!done && guard < 5000);
    #1;
    chk(done, "R5", "transfer finished", done, 1);
    chk(doneCycle == lastHsCycle + 1, "R5", "done one cycle after last handshake",
        doneCycle, lastHsCycle + 1);
    chk(expQ.size() == 0, "R3", "all expected words pushed", expQ.size(), 0);
    expQ.delete();
    chk(pushCount - pushBefore == 2 + (wr ? n : 0), "R8", "push count",
        pushCount - pushBefore, 2 + (wr ? n : 0));
    if (!wr) begin
      chk(memIdx == n, "R4", "words popped", memIdx, n);
      for (int i = 0; i < n; i++) begin
        bufRdIdx = 6'(i);
        #0.1;
        chk(bufRdData == rdWords[i], "R4", "read word stored in order", bufRdData, rdWords[i]);
        mdl[i] = rdWords[i];
      end
    end
    if (poke) begin
      bufRdIdx = 6'd63;
      #0.1;
      chk(bufRdData == mdl[63], "R9", "busy buffer write ignored", bufRdData, mdl[63]);
    end
    rdCount = 0;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R1", "reset done", done, 1);
    chk(err == 1'b0, "R1", "reset err", err, 0);
    chk(outValid == 1'b0, "R1", "reset outValid", outValid, 0);
    chk(inReady == 1'b0, "R1", "reset inReady", inReady, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(done && !err && !outValid && !inReady, "R1", "idle after reset",
        {done, err, outValid, inReady}, 32'h8);

    loadBuffer(32'h1234_0000);
    stallMode = 0; runCmd(1'b1, 24'd4, 32'h0000_1000, 1'b0);   // R10 single write
    stallMode = 1; runCmd(1'b1, 24'd20, 32'h0000_0100, 1'b0);  // R3 with R7 stalls
    stallMode = 0; runCmd(1'b0, 24'd12, 32'h0000_2000, 1'b0);  // R4
    stallMode = 2; runCmd(1'b0, 24'd28, 32'h0000_2040, 1'b0);  // R4 with R7 gaps
    stallMode = 0; runCmd(1'b0, 24'd4, 32'h0000_2080, 1'b0);   // R10 single read
    // R6 refused commands
    runCmd(1'b1, 24'd0, 32'h0000_0000, 1'b0);
    runCmd(1'b0, 24'd6, 32'h0000_0000, 1'b0);
    runCmd(1'b1, 24'd260, 32'h0000_0000, 1'b0);
    runCmd(1'b0, 24'd8, 32'h0000_0102, 1'b0);
    runCmd(1'b0, 24'd8, 32'h0000_3000, 1'b0);                   // R6 err cleared
    loadBuffer(32'h5A5A_0000);
    stallMode = 2; runCmd(1'b1, 24'd16, 32'h0000_0200, 1'b1);  // R8 and R9
    stallMode = 2; runCmd(1'b1, 24'd256, 32'h0000_4000, 1'b0); // R10 full write
    stallMode = 1; runCmd(1'b0, 24'd256, 32'h0000_8000, 1'b0); // R10 full read
    stallMode = 0; runCmd(1'b1, 24'd256, 32'h0000_C000, 1'b0); // R10 echo of read data

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule